// File: doc/BRIEF.md
# I2C Address Alias Router

This block looks at the 7-bit address of every I2C transaction presented on a local slave port and decides where that transaction belongs. It can go to the device's own register file, to the remote serializer at the far end of the control channel, or to one of eight remote slaves that are reached through alias addresses. For an alias hit, the block swaps the alias for the paired physical target address, and that target is what travels across the control channel.

The block is configured through a byte-wide register write port. The table holds eight entries. Each entry has an alias and a target, and an alias of zero turns its entry off. The remote serializer ID reloads itself from the forward channel until software freezes it. A pass-through-all bit forwards every transaction that no higher-priority route claims. A local-write-disable bit rejects register writes that arrive from the remote side and are addressed to this device.

A decision appears on the outputs one clock after the address strobe. It stays there until the next strobe.

Top module: `addr_alias_router`

## Requirements
- R1: An address equal to `local_id` is routed with code 1 (local), and `xlat_addr` carries the address unchanged. This takes priority over every other match.
- R2: An address equal to a nonzero remote serializer ID, and not claimed by R1, is routed with code 2 (remote serializer), and `xlat_addr` carries the address unchanged.
- R3: An address equal to a nonzero alias, and not claimed by R1 or R2, is routed with code 3 (alias), and `xlat_addr` carries the paired target. When several aliases match, the lowest entry index wins.
- R4: An alias of 0 never matches, and neither does a remote serializer ID of 0. A transaction to address 0 is therefore never routed to the remote serializer or to an alias.
- R5: Register map (byte writes, 7-bit values held in bits 7:1):
  - Offset 0x00 is control: bit0 pass-through-all, bit1 local-write-disable, bit2 freeze.
  - Offset 0x01 is the remote serializer ID.
  - Offsets 0x08+i hold alias i.
  - Offsets 0x10+i hold target i.
  - After reset, control is 0, the remote serializer ID is 0x0C (byte 0x18), alias 3 is 0x08 (byte 0x10), and every other alias and target is 0.
- R6: A `fc_id_vld` pulse loads `fc_id` into the remote serializer ID while freeze is 0. While freeze is 1 the ID keeps the value software last wrote. A software write in the same cycle as a load takes precedence over the load.
- R7: With pass-through-all set, an address that matches none of R1 to R3 is routed with code 4 (pass-through), and `xlat_addr` carries the address unchanged.
- R8: With local-write-disable set, a transaction that targets `local_id` with `from_remote`=1 and `is_write`=1 is routed with code 0. Remote reads and local-side writes still get code 1, and remote writes to other routes are unaffected.
- R9: An address that no route claims gets code 0, with `xlat_addr` = 0.
- R10: `route_vld` is high for exactly the one cycle after each `addr_stb`. `route` and `xlat_addr` hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_id | input | 7 | This device's own slave address |
| addr_stb | input | 1 | Address of a new transaction is present |
| addr_in | input | 7 | Transaction address |
| is_write | input | 1 | Transaction is a write |
| from_remote | input | 1 | Transaction arrived over the control channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| fc_id_vld | input | 1 | Forward channel presents a serializer ID |
| fc_id | input | 7 | Serializer ID from the forward channel |
| route_vld | output | 1 | Routing decision updated this cycle |
| route | output | 3 | Route code: 0 none, 1 local, 2 serializer, 3 alias, 4 pass-through |
| xlat_addr | output | 7 | Address to forward (target on alias hit) |

## Verification
Every piece of internal state is visible at the ports on the very next strobe. A corrupted alias or target shows up as a wrong route code or a wrong `xlat_addr`, one cycle after a strobe carrying that alias. A remote ID that was overwritten while frozen turns the old ID into a miss and the new one into a serializer hit. A priority error shows only when an address matches two routes at once, so the stimulus deliberately repeats table values across entries and against `local_id`. Reset values are exposed by the first transactions after reset, before any write.

// File: rtl/alias_pkg.sv
package alias_pkg;
  localparam int ROUTE_W = 3;

  typedef enum logic [ROUTE_W-1:0] {
    RT_NONE   = 3'd0,
    RT_LOCAL  = 3'd1,
    RT_REMOTE = 3'd2,
    RT_ALIAS  = 3'd3,
    RT_PASS   = 3'd4
  } route_e;

  localparam logic [5:0] CTRL_OFS = 6'h00;
  localparam logic [5:0] RID_OFS  = 6'h01;
  localparam int CTRL_PASS_BIT   = 0;
  localparam int CTRL_LWD_BIT    = 1;
  localparam int CTRL_FREEZE_BIT = 2;
endpackage

// File: rtl/alias_cfg_regs.sv
module alias_cfg_regs
  import alias_pkg::*;
#(
  parameter int N_ALIAS       = 8,
  parameter int AW            = 7,
  parameter int CFG_AW        = 6,
  parameter int ALIAS_BASE    = 8,
  parameter int TARGET_BASE   = 16,
  parameter logic [AW-1:0] RID_RST = 7'h0C,
  parameter int RST_ALIAS_IDX = 3,
  parameter logic [AW-1:0] RST_ALIAS_VAL = 7'h08
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [AW:0]                cfg_wdata,
  input  logic                       fc_id_vld,
  input  logic [AW-1:0]              fc_id,
  output logic [N_ALIAS-1:0][AW-1:0] alias_tab,
  output logic [N_ALIAS-1:0][AW-1:0] target_tab,
  output logic [AW-1:0]              rid,
  output logic                       pass_all,
  output logic                       lwd,
  output logic                       freeze
);
  logic          ctrl_wr, rid_wr, fc_ld;
  logic [AW-1:0] rid_d;
  logic          pass_d, lwd_d, freeze_d;

  assign ctrl_wr = cfg_we && (cfg_addr == CFG_AW'(CTRL_OFS));
  assign rid_wr  = cfg_we && (cfg_addr == CFG_AW'(RID_OFS));
  assign fc_ld   = fc_id_vld && !freeze && !rid_wr;

  always_comb begin
    pass_d   = pass_all;
    lwd_d    = lwd;
    freeze_d = freeze;
    if (ctrl_wr) begin
      pass_d   = cfg_wdata[CTRL_PASS_BIT];
      lwd_d    = cfg_wdata[CTRL_LWD_BIT];
      freeze_d = cfg_wdata[CTRL_FREEZE_BIT];
    end
  end

  always_comb begin
    rid_d = rid;
    if (rid_wr)     rid_d = cfg_wdata[AW:1];
    else if (fc_ld) rid_d = fc_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_all <= 1'b0;
      lwd      <= 1'b0;
      freeze   <= 1'b0;
      rid      <= RID_RST;
    end else begin
      if (ctrl_wr) begin
        pass_all <= pass_d;
        lwd      <= lwd_d;
        freeze   <= freeze_d;
      end
      if (rid_wr || fc_ld) rid <= rid_d;
    end
  end

  for (genvar gi = 0; gi < N_ALIAS; gi++) begin : g_entry
    localparam logic [AW-1:0] A_RST = (gi == RST_ALIAS_IDX) ? RST_ALIAS_VAL : '0;
    logic a_wr, t_wr;
    logic [AW-1:0] a_d, t_d;

    assign a_wr = cfg_we && (cfg_addr == CFG_AW'(ALIAS_BASE + gi));
    assign t_wr = cfg_we && (cfg_addr == CFG_AW'(TARGET_BASE + gi));

    always_comb begin
      a_d = a_wr ? cfg_wdata[AW:1] : alias_tab[gi];
      t_d = t_wr ? cfg_wdata[AW:1] : target_tab[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alias_tab[gi]  <= A_RST;
        target_tab[gi] <= '0;
      end else begin
        if (a_wr) alias_tab[gi]  <= a_d;
        if (t_wr) target_tab[gi] <= t_d;
      end
    end
  end

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !rid_wr) |=> $stable(rid));

  // R6
  fc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_id_vld && !freeze && !rid_wr) |=> (rid == $past(fc_id)));

  // R6
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rid_wr |=> (rid == $past(cfg_wdata[AW:1])));
endmodule

// File: rtl/alias_match.sv
module alias_match #(
  parameter int N_ALIAS = 8,
  parameter int AW      = 7,
  localparam int IDX_W  = (N_ALIAS > 1) ? $clog2(N_ALIAS) : 1
) (
  input  logic [AW-1:0]              addr,
  input  logic [N_ALIAS-1:0][AW-1:0] alias_tab,
  input  logic [N_ALIAS-1:0][AW-1:0] target_tab,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx,
  output logic [AW-1:0]              hit_target
);
  logic [N_ALIAS-1:0] eq;

  for (genvar gi = 0; gi < N_ALIAS; gi++) begin : g_cmp
    assign eq[gi] = (alias_tab[gi] != '0) && (alias_tab[gi] == addr);
  end

  always_comb begin
    hit        = 1'b0;
    hit_idx    = '0;
    hit_target = '0;
    for (int i = N_ALIAS - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit        = 1'b1;
        hit_idx    = IDX_W'(i);
        hit_target = target_tab[i];
      end
    end
  end

  always_comb begin
    // R4
    alias_nonzero_chk: assert (!hit || (addr != '0));
  end
endmodule

// File: rtl/route_sel.sv
module route_sel
  import alias_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_stb,
  input  logic [AW-1:0]      addr,
  input  logic               is_write,
  input  logic               from_remote,
  input  logic [AW-1:0]      local_id,
  input  logic [AW-1:0]      rid,
  input  logic               pass_all,
  input  logic               lwd,
  input  logic               alias_hit,
  input  logic [AW-1:0]      alias_target,
  output logic               route_vld,
  output logic [ROUTE_W-1:0] route,
  output logic [AW-1:0]      xlat_addr
);
  route_e        route_d;
  logic [AW-1:0] xlat_d;
  logic          blocked;

  assign blocked = from_remote && is_write && lwd;

  always_comb begin
    route_d = RT_NONE;
    xlat_d  = '0;
    if (addr == local_id) begin
      if (!blocked) begin
        route_d = RT_LOCAL;
        xlat_d  = addr;
      end
    end else if ((rid != '0) && (addr == rid)) begin
      route_d = RT_REMOTE;
      xlat_d  = addr;
    end else if (alias_hit) begin
      route_d = RT_ALIAS;
      xlat_d  = alias_target;
    end else if (pass_all) begin
      route_d = RT_PASS;
      xlat_d  = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_vld <= 1'b0;
      route     <= ROUTE_W'(RT_NONE);
      xlat_addr <= '0;
    end else begin
      route_vld <= addr_stb;
      if (addr_stb) begin
        route     <= route_d;
        xlat_addr <= xlat_d;
      end
    end
  end

  // R1
  local_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && (addr == local_id) && !(from_remote && is_write))
      |=> (route == ROUTE_W'(RT_LOCAL)) && (xlat_addr == $past(addr)));

  // R8
  lwd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && (addr == local_id) && from_remote && is_write && lwd)
      |=> (route == ROUTE_W'(RT_NONE)));

  // R2
  rid_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_vld && (route == ROUTE_W'(RT_REMOTE))) |-> (xlat_addr != '0));

  // R10
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> route_vld);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_stb |=> (!route_vld && $stable(route) && $stable(xlat_addr)));

  // R9
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_vld |-> (route <= ROUTE_W'(RT_PASS)));
endmodule

// File: rtl/addr_alias_router.sv
module addr_alias_router
  import alias_pkg::*;
#(
  parameter int N_ALIAS       = 8,
  parameter int AW            = 7,
  parameter int CFG_AW        = 6,
  parameter int ALIAS_BASE    = 8,
  parameter int TARGET_BASE   = 16,
  parameter logic [AW-1:0] RID_RST = 7'h0C,
  parameter int RST_ALIAS_IDX = 3,
  parameter logic [AW-1:0] RST_ALIAS_VAL = 7'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     local_id,
  input  logic              addr_stb,
  input  logic [AW-1:0]     addr_in,
  input  logic              is_write,
  input  logic              from_remote,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [AW:0]       cfg_wdata,
  input  logic              fc_id_vld,
  input  logic [AW-1:0]     fc_id,
  output logic              route_vld,
  output logic [2:0]        route,
  output logic [AW-1:0]     xlat_addr
);
  localparam int IDX_W = (N_ALIAS > 1) ? $clog2(N_ALIAS) : 1;

  logic [N_ALIAS-1:0][AW-1:0] alias_tab, target_tab;
  logic [AW-1:0]              rid, hit_target;
  logic                       pass_all, lwd, freeze, hit;
  logic [IDX_W-1:0]           hit_idx;

  alias_cfg_regs #(
    .N_ALIAS(N_ALIAS), .AW(AW), .CFG_AW(CFG_AW),
    .ALIAS_BASE(ALIAS_BASE), .TARGET_BASE(TARGET_BASE),
    .RID_RST(RID_RST), .RST_ALIAS_IDX(RST_ALIAS_IDX),
    .RST_ALIAS_VAL(RST_ALIAS_VAL)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fc_id_vld(fc_id_vld), .fc_id(fc_id),
    .alias_tab(alias_tab), .target_tab(target_tab),
    .rid(rid), .pass_all(pass_all), .lwd(lwd), .freeze(freeze)
  );

  alias_match #(.N_ALIAS(N_ALIAS), .AW(AW)) i_match (
    .addr(addr_in), .alias_tab(alias_tab), .target_tab(target_tab),
    .hit(hit), .hit_idx(hit_idx), .hit_target(hit_target)
  );

  route_sel #(.AW(AW)) i_sel (
    .clk(clk), .rst_n(rst_n),
    .addr_stb(addr_stb), .addr(addr_in),
    .is_write(is_write), .from_remote(from_remote),
    .local_id(local_id), .rid(rid),
    .pass_all(pass_all), .lwd(lwd),
    .alias_hit(hit), .alias_target(hit_target),
    .route_vld(route_vld), .route(route), .xlat_addr(xlat_addr)
  );

  // R3
  alias_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (alias_tab[hit_idx] == addr_in));

  // R6
  freeze_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && fc_id_vld && !cfg_we) |=> $stable(rid));
endmodule

// File: tb/test_addr_alias_router.sv
module test_addr_alias_router;
  localparam logic [6:0] LID = 7'h2C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_stb = 1'b0, is_write = 1'b0, from_remote = 1'b0;
  logic [6:0] addr_in = '0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       fc_id_vld = 1'b0;
  logic [6:0] fc_id = '0;
  logic       route_vld;
  logic [2:0] route;
  logic [6:0] xlat_addr;

  int n_chk = 0, n_bad = 0;

  logic [6:0] m_al [8];
  logic [6:0] m_tg [8];
  logic [6:0] m_rid;
  logic m_pass, m_lwd, m_frz;

  always #10 clk = ~clk;

  addr_alias_router i_addr_alias_router (
    .clk(clk), .rst_n(rst_n), .local_id(LID),
    .addr_stb(addr_stb), .addr_in(addr_in), .is_write(is_write),
    .from_remote(from_remote), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fc_id_vld(fc_id_vld), .fc_id(fc_id),
    .route_vld(route_vld), .route(route), .xlat_addr(xlat_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] expect_fn(input logic [6:0] a, input bit wr, input bit rem);
    if (a == LID) begin
      if (rem && wr && m_lwd) return {3'd0, 7'd0};
      return {3'd1, a};
    end
    if (m_rid != 0 && a == m_rid) return {3'd2, a};
    for (int i = 0; i < 8; i++)
      if (m_al[i] != 0 && a == m_al[i]) return {3'd3, m_tg[i]};
    if (m_pass) return {3'd4, a};
    return {3'd0, 7'd0};
  endfunction

  task automatic cfg_wr(input logic [5:0] ofs, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ofs == 6'h00) begin m_pass = d[0]; m_lwd = d[1]; m_frz = d[2]; end
    else if (ofs == 6'h01) m_rid = d[7:1];
    else if (ofs >= 6'h08 && ofs < 6'h10) m_al[ofs-8] = d[7:1];
    else if (ofs >= 6'h10 && ofs < 6'h18) m_tg[ofs-16] = d[7:1];
  endtask

  task automatic fc_load(input logic [6:0] v);
    @(negedge clk);
    fc_id_vld = 1'b1; fc_id = v;
    @(negedge clk);
    fc_id_vld = 1'b0;
    if (!m_frz) m_rid = v;
  endtask

  task automatic txn(input logic [6:0] a, input bit wr, input bit rem, input string req);
    logic [9:0] e;
    logic [2:0] r0;
    logic [6:0] x0;
    e = expect_fn(a, wr, rem);
    @(negedge clk);
    addr_stb = 1'b1; addr_in = a; is_write = wr; from_remote = rem;
    @(negedge clk);
    addr_stb = 1'b0; addr_in = $urandom; is_write = $urandom; from_remote = $urandom;
    check(route_vld == 1'b1, {req, " vld"}, route_vld, 1);
    check(route == e[9:7], {req, " route"}, route, e[9:7]);
    check(xlat_addr == e[6:0], {req, " xlat"}, xlat_addr, e[6:0]);
    r0 = route; x0 = xlat_addr;
    @(negedge clk);
    check(!route_vld && route == r0 && xlat_addr == x0, "R10 hold", {route_vld, route}, {1'b0, r0});
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [6:0] v;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) begin m_al[i] = 0; m_tg[i] = 0; end
    m_al[3] = 7'h08; m_rid = 7'h0C; m_pass = 0; m_lwd = 0; m_frz = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!route_vld && route == 0 && xlat_addr == 0, "R5 reset outputs", route, 0);
    // R5 reset table contents
    txn(7'h0C, 0, 0, "R5 rid reset");
    txn(7'h08, 0, 0, "R5 alias3 reset");
    txn(7'h00, 0, 0, "R4 addr zero");
    txn(7'h11, 0, 0, "R9 no match");
    txn(LID, 1, 1, "R1 local");
    // R3 priority: two aliases share one value
    cfg_wr(6'h0D, {7'h40, 1'b0}); cfg_wr(6'h15, {7'h55, 1'b0});
    cfg_wr(6'h09, {7'h40, 1'b0}); cfg_wr(6'h11, {7'h22, 1'b0});
    txn(7'h40, 0, 0, "R3 lowest index");
    // R1 beats alias, R2 beats alias
    cfg_wr(6'h0A, {LID, 1'b0});
    txn(LID, 0, 0, "R1 priority");
    cfg_wr(6'h0E, {7'h0C, 1'b0});
    txn(7'h0C, 0, 0, "R2 priority");
    // R6 forward-channel load and freeze
    fc_load(7'h33);
    txn(7'h33, 0, 0, "R6 fc load");
    txn(7'h0C, 0, 0, "R6 old id gone");
    cfg_wr(6'h00, 8'h04); cfg_wr(6'h01, {7'h5A, 1'b0});
    fc_load(7'h61);
    txn(7'h5A, 0, 0, "R6 frozen keeps");
    txn(7'h61, 0, 0, "R6 frozen ignores");
    // R6 software write beats same-cycle load
    cfg_wr(6'h00, 8'h00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'h01; cfg_wdata = {7'h27, 1'b0};
    fc_id_vld = 1'b1; fc_id = 7'h19;
    @(negedge clk);
    cfg_we = 1'b0; fc_id_vld = 1'b0; m_rid = 7'h27;
    txn(7'h27, 0, 0, "R6 sw wins");
    // R4 rid zero disables
    cfg_wr(6'h01, 8'h00);
    txn(7'h00, 0, 0, "R4 rid zero");
    // R7 pass-through
    cfg_wr(6'h00, 8'h01);
    txn(7'h7E, 0, 0, "R7 pass");
    txn(7'h40, 0, 0, "R7 alias over pass");
    // R8 local write disable
    cfg_wr(6'h00, 8'h02);
    txn(LID, 1, 1, "R8 remote write blocked");
    txn(LID, 0, 1, "R8 remote read");
    txn(LID, 1, 0, "R8 local write");
    txn(7'h40, 1, 1, "R8 alias write unaffected");
    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        int s;
        s = $urandom_range(0, 17);
        if (s == 0) cfg_wr(6'h00, 8'($urandom_range(0, 7)));
        else if (s == 1) cfg_wr(6'h01, 8'($urandom));
        else if (s < 10) cfg_wr(6'(8 + s - 2), {7'($urandom_range(0, 7) * 16), 1'b0});
        else cfg_wr(6'(16 + s - 10), 8'($urandom));
      end else if (op == 3) begin
        fc_load(7'($urandom_range(0, 7) * 16 + 12));
      end else begin
        int p;
        p = $urandom_range(0, 3);
        if (p == 0) v = m_al[$urandom_range(0, 7)];
        else if (p == 1) v = m_rid;
        else if (p == 2) v = LID;
        else v = 7'($urandom);
        txn(v, 1'($urandom), 1'($urandom), "R3 random");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule